// File: doc/BRIEF.md
# Prefix-Based Carry Select Adder

This block adds two 8-bit operands and a carry-in, and it returns an 8-bit sum and a carry-out. It has no clock and no state. The result is valid as soon as the inputs settle. It is meant for datapaths where an add has to fit inside one cycle of the surrounding logic.

The word is split into two 4-bit groups. The low group is added by a parallel-prefix adder that takes the real carry-in. The high group is added once, by a second parallel-prefix adder whose carry-in is tied to zero. That 4-bit sum and its group carry form a 5-bit value. A 5-bit add-one converter turns this value into the result for a carry-in of one.

A small select stage turns the low group's carry-out into a pair of mutually exclusive strobes. These strobes steer a multiplexer that picks the direct high result or the incremented one. The selected value supplies the upper four sum bits and the carry-out.

Top module: `prefixCarrySelectAdder`

## Requirements
- R1: For every input combination, {carryOut, sumOut} equals opA + opB + carryIn as a 9-bit unsigned value.
- R2: sumOut[3:0] equals the low 4 bits of opA[3:0] + opB[3:0] + carryIn, whatever the upper operand bits are.
- R3: A carry-in of 1 adds exactly one to the result. This holds at the full wrap point: opA = 8'hFF, opB = 8'h00, carryIn = 1 gives sumOut = 8'h00 and carryOut = 1.
- R4: carryOut is 1 exactly when opA + opB + carryIn is 256 or more.
- R5: When the low group produces no carry (opA[3:0] + opB[3:0] + carryIn < 16), {carryOut, sumOut[7:4]} equals opA[7:4] + opB[7:4].
- R6: When the low group produces a carry, {carryOut, sumOut[7:4]} equals opA[7:4] + opB[7:4] + 1. This includes the case where the high nibbles sum to 15, which gives sumOut[7:4] = 0 and carryOut = 1.
- R7: The converter maps the 5-bit value {c, s3..s0} to that value plus one, modulo 32. Output bit k is input bit k XOR the AND of all lower input bits, and bit 0 is inverted.
- R8: The block is purely combinational. The outputs follow a change of the inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sumOut | output | 8 | Sum bits |
| carryOut | output | 1 | Carry out of bit 7 |

## Verification
Immediate assertions run each time the inputs change:
- each prefix adder must return the arithmetic sum of its own inputs;
- the converter must return its input plus one;
- the high result must equal the direct group sum, or that sum plus one, as the select strobes say;
- the full output must match opA + opB + carryIn.

Only the bench's scenarios show the other properties. These are:
- that the low nibble ignores the upper operand bits;
- that the wrap cases (all-ones high nibbles with a low carry, and 8'hFF plus a carry-in) are actually reached;
- that the result appears with no clock edge, since the bench changes inputs and samples half a period later.

The bench sweeps all 2^17 input combinations, adds seeded random vectors, and adds directed corner vectors.

// File: rtl/pcsaPkg.sv
package pcsaPkg;

  // Steering strobes from the select control to the high-group datapath.
  typedef struct packed {
    logic useIncremented;
    logic useDirect;
  } selStrobe_t;

endpackage

// File: rtl/prefixGroupAdder.sv
// Parallel-prefix adder of one group. The carry network has log2(W) levels.
// At each level a node merges with the last node of the block below it, which gives minimum depth.
module prefixGroupAdder #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  localparam int LVLS = (W > 1) ? $clog2(W) : 1;

  logic [W-1:0] bitProp;
  logic [W-1:0] bitGen;
  logic [LVLS:0][W-1:0] netGen;
  logic [LVLS:0][W-1:0] netProp;
  logic [W:0] carry;

  // Pre-processing: per-bit propagate and generate.
  assign bitProp = a ^ b;
  assign bitGen  = a & b;

  // Prefix carry network: the upper span merges with the lower span.
  always_comb begin
    netGen[0]  = bitGen;
    netProp[0] = bitProp;
    for (int lv = 0; lv < LVLS; lv++) begin
      for (int i = 0; i < W; i++) begin
        if (((i >> lv) & 1) == 1) begin
          netGen[lv+1][i]  = netGen[lv][i] |
                             (netProp[lv][i] & netGen[lv][((i >> lv) << lv) - 1]);
          netProp[lv+1][i] = netProp[lv][i] & netProp[lv][((i >> lv) << lv) - 1];
        end else begin
          netGen[lv+1][i]  = netGen[lv][i];
          netProp[lv+1][i] = netProp[lv][i];
        end
      end
    end
  end

  // Post-processing: fold the carry-in into each prefix term and form the sums.
  always_comb begin
    carry[0] = cin;
    for (int i = 0; i < W; i++) begin
      carry[i+1] = netGen[LVLS][i] | (netProp[LVLS][i] & cin);
    end
  end

  assign sum  = bitProp ^ carry[W-1:0];
  assign cout = carry[W];

  // R1: the group result is the arithmetic sum of its inputs
  always_comb begin
    if (!$isunknown({a, b, cin})) begin
      p_group_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin}))
        else $error("group adder mismatch a=%0h b=%0h cin=%0b", a, b, cin);
    end
  end

endmodule

// File: rtl/excessOneConverter.sv
// Adds one to a (W+1)-bit value: each bit flips when all lower bits are one.
module excessOneConverter #(
  parameter int W = 4
) (
  input  logic [W:0] valIn,
  output logic [W:0] valOut
);
  logic [W:0] lowerOnes;

  always_comb begin
    lowerOnes[0] = 1'b1;
    for (int k = 1; k <= W; k++) begin
      lowerOnes[k] = lowerOnes[k-1] & valIn[k-1];
    end
  end

  for (genvar k = 0; k <= W; k++) begin : g_flip
    assign valOut[k] = valIn[k] ^ lowerOnes[k];
  end

  // R7: the output is the input plus one, wrapping at 2^(W+1)
  always_comb begin
    if (!$isunknown(valIn)) begin
      p_add_one_r7: assert (valOut == valIn + {{W{1'b0}}, 1'b1})
        else $error("converter mismatch in=%0h out=%0h", valIn, valOut);
    end
  end

endmodule

// File: rtl/carrySelectCtrl.sv
// Turns the carry from the lower group into the steering strobes.
module carrySelectCtrl
  import pcsaPkg::*;
(
  input  logic       lowCarry,
  output selStrobe_t strobes
);
  always_comb begin
    strobes.useIncremented = lowCarry;
    strobes.useDirect      = ~lowCarry;
  end
endmodule

// File: rtl/highGroupPath.sv
// High-group datapath: a carry-in-zero prefix add, an add-one converter and the result multiplexer.
module highGroupPath
  import pcsaPkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  selStrobe_t   strobes,
  output logic [W-1:0] sumHi,
  output logic         coutHi
);
  logic [W-1:0] directSum;
  logic         directCarry;
  logic [W:0]   incValue;
  logic [W:0]   chosen;

  prefixGroupAdder #(.W(W)) u_zeroAdd (
    .a   (a),
    .b   (b),
    .cin (1'b0),
    .sum (directSum),
    .cout(directCarry)
  );

  excessOneConverter #(.W(W)) u_inc (
    .valIn ({directCarry, directSum}),
    .valOut(incValue)
  );

  always_comb begin
    chosen = {directCarry, directSum};
    if (strobes.useIncremented) chosen = incValue;
  end

  assign sumHi  = chosen[W-1:0];
  assign coutHi = chosen[W];

  // R5 and R6: the selected result follows the strobe
  always_comb begin
    if (!$isunknown({a, b, strobes})) begin
      p_strobe_onehot_r6: assert ($onehot(strobes))
        else $error("select strobes not one-hot");
      if (strobes.useDirect) begin
        p_direct_pick_r5: assert ({coutHi, sumHi} == ({1'b0, a} + {1'b0, b}))
          else $error("direct pick wrong");
      end
      if (strobes.useIncremented) begin
        p_inc_pick_r6: assert ({coutHi, sumHi} == ({1'b0, a} + {1'b0, b} + 1'b1))
          else $error("incremented pick wrong");
      end
    end
  end

endmodule

// File: rtl/prefixCarrySelectAdder.sv
// Top: a low prefix group with the real carry-in selects the high group's result.
module prefixCarrySelectAdder
  import pcsaPkg::*;
#(
  parameter int WIDTH = 8,
  parameter int LOW_W = 4
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             carryIn,
  output logic [WIDTH-1:0] sumOut,
  output logic             carryOut
);
  localparam int HIGH_W = WIDTH - LOW_W;

  logic [LOW_W-1:0]  lowSum;
  logic              lowCarry;
  logic [HIGH_W-1:0] highSum;
  selStrobe_t        strobes;

  prefixGroupAdder #(.W(LOW_W)) u_lowAdd (
    .a   (opA[LOW_W-1:0]),
    .b   (opB[LOW_W-1:0]),
    .cin (carryIn),
    .sum (lowSum),
    .cout(lowCarry)
  );

  carrySelectCtrl u_ctrl (
    .lowCarry(lowCarry),
    .strobes (strobes)
  );

  highGroupPath #(.W(HIGH_W)) u_high (
    .a      (opA[WIDTH-1:LOW_W]),
    .b      (opB[WIDTH-1:LOW_W]),
    .strobes(strobes),
    .sumHi  (highSum),
    .coutHi (carryOut)
  );

  assign sumOut = {highSum, lowSum};

  // R1 and R4: full-width arithmetic result
  always_comb begin
    if (!$isunknown({opA, opB, carryIn})) begin
      p_full_sum_r1: assert ({carryOut, sumOut} ==
                             ({1'b0, opA} + {1'b0, opB} + {{WIDTH{1'b0}}, carryIn}))
        else $error("adder mismatch a=%0h b=%0h cin=%0b", opA, opB, carryIn);
    end
  end

endmodule

// File: tb/prefixCarrySelectAdder_test.sv
module prefixCarrySelectAdder_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;   // 100 MHz

  logic [7:0] opA;
  logic [7:0] opB;
  logic       carryIn;
  logic [7:0] sumOut;
  logic       carryOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  prefixCarrySelectAdder uut (
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .sumOut  (sumOut),
    .carryOut(carryOut)
  );

  function automatic logic [8:0] expFull(input logic [7:0] a, input logic [7:0] b, input logic c);
    return {1'b0, a} + {1'b0, b} + {8'd0, c};
  endfunction

  function automatic logic [4:0] expLow(input logic [7:0] a, input logic [7:0] b, input logic c);
    return {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'd0, c};
  endfunction

  function automatic logic [4:0] expHigh(input logic [7:0] a, input logic [7:0] b, input logic lc);
    return {1'b0, a[7:4]} + {1'b0, b[7:4]} + {4'd0, lc};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s a=%0h b=%0h cin=%0b actual=%0h expected=%0h",
               tag, opA, opB, carryIn, act, exp);
    end
  endtask

  // Drive after a rising edge, sample at the following falling edge.
  task automatic applyCheck(input logic [7:0] a, input logic [7:0] b, input logic c);
    logic [8:0] full;
    logic [4:0] lo;
    logic [4:0] hi;
    @(posedge clk);
    opA = a; opB = b; carryIn = c;
    @(negedge clk);
    full = expFull(a, b, c);
    lo   = expLow(a, b, c);
    hi   = expHigh(a, b, lo[4]);
    check({carryOut, sumOut} == full, "R1", {carryOut, sumOut}, full);
    if (lo[4]) check({carryOut, sumOut[7:4]} == hi, "R6", {4'd0, carryOut, sumOut[7:4]}, {4'd0, hi});
    else       check({carryOut, sumOut[7:4]} == hi, "R5", {4'd0, carryOut, sumOut[7:4]}, {4'd0, hi});
  endtask

  initial begin
    opA = 8'h00; opB = 8'h00; carryIn = 1'b0;
    void'($urandom(32'h5EED_0042));

    // reset-like idle state: zero inputs give zero outputs (R1)
    @(negedge clk);
    check({carryOut, sumOut} == 9'h000, "R1 idle", {carryOut, sumOut}, 9'h000);

    // R8: outputs follow an input change with no clock edge in between
    @(posedge clk);
    #1 opA = 8'h3C; opB = 8'h05; carryIn = 1'b1;
    #1 check({carryOut, sumOut} == 9'h042, "R8", {carryOut, sumOut}, 9'h042);

    // R3: wrap at all ones with a carry-in
    applyCheck(8'hFF, 8'h00, 1'b1);
    check(sumOut == 8'h00 && carryOut, "R3", {carryOut, sumOut}, 9'h100);
    applyCheck(8'h7E, 8'h01, 1'b1);
    check({carryOut, sumOut} == 9'h080, "R3", {carryOut, sumOut}, 9'h080);

    // R4: carry-out boundary at 255 and 256
    applyCheck(8'hF0, 8'h0F, 1'b0);
    check(carryOut == 1'b0, "R4", {8'd0, carryOut}, 9'd0);
    applyCheck(8'hF0, 8'h0F, 1'b1);
    check(carryOut == 1'b1, "R4", {8'd0, carryOut}, 9'd1);

    // R6 and R7: high nibbles sum to 15 with a low carry, so the converter wraps
    applyCheck(8'h9F, 8'h61, 1'b0);
    check(sumOut[7:4] == 4'h0 && carryOut, "R7", {4'd0, carryOut, sumOut[7:4]}, 9'h010);

    // R2: the low nibble ignores the upper operand bits
    for (int u = 0; u < 16; u++) begin
      applyCheck({u[3:0], 4'h9}, {4'hF - u[3:0], 4'h6}, 1'b1);
      check(sumOut[3:0] == 4'h0, "R2", {5'd0, sumOut[3:0]}, 9'd0);
    end

    // seeded random vectors
    for (int n = 0; n < 2000; n++) begin
      logic [31:0] r;
      r = $urandom;
      applyCheck(r[7:0], r[15:8], r[16]);
    end

    // exhaustive sweep over all 2^17 combinations (R1, R4, R5, R6)
    for (int c = 0; c < 2; c++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          applyCheck(a[7:0], b[7:0], c[0]);
        end
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule